// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one cell of a programmable-logic fabric together with the driver control of its I/O pad. It accepts a sum-of-products term from the logic array and passes it to the pad along one of three paths. The path can go through an edge-triggered flip-flop that works as D or T storage, through a level-sensitive latch, or straight through with no storage. A static inversion bit sets the polarity seen at the pad. A three-way output-enable mode controls the pad driver: it can be held on, held off, or follow one of several candidate enable terms.

Storage can be forced low or high at any time by the asynchronous clear and set terms. Clear wins when both are asserted. A synchronous active-high reset also brings the storage to 0. A feedback output returns the internal state to the array, taken before the polarity stage. A buried build of the same cell, selected by a parameter, never drives its pad. Instead it samples the pad input in a flop or a latch and offers the sampled value as feedback.

Top module: `pld_macrocell`

## Requirements
- R1: `cfg_path` picks the data path: 2'b00 flip-flop, 2'b01 latch, 2'b10 or 2'b11 combinational. In combinational mode `pin_dout` equals `sum_term` XOR `cfg_invert` with no clock involved.
- R2: With `cfg_invert` = 1 the pad data `pin_dout` is the complement of the selected state. With `cfg_invert` = 0 it is the state itself.
- R3: In flip-flop mode with `cfg_t_type` = 0, the state takes the value of `sum_term` at each rising `clk` edge.
- R4: In flip-flop mode with `cfg_t_type` = 1, the state inverts at a rising `clk` edge when `sum_term` is 1 and holds when it is 0.
- R5: In latch mode the state follows `sum_term` while `latch_gate` is 1 and holds its value while `latch_gate` is 0, whatever `clk` does.
- R6: `ar_term` = 1 forces the state to 0 and `ap_term` = 1 forces it to 1, without waiting for a clock edge. When both are 1 the state is 0.
- R7: `cfg_oe_mode` sets `pin_oe`: 2'b00 always 1, 2'b01 and 2'b11 always 0, 2'b10 product-term controlled.
- R8: In product-term mode, `pin_oe` equals `oe_terms[cfg_oe_sel]`.
- R9: The buried build (BURIED = 1) holds `pin_oe` and `pin_dout` at 0. It captures `pin_in` into its feedback state, through a flip-flop on rising `clk` when `cfg_in_latch` = 0, or through a latch transparent on `latch_gate` = 1 when `cfg_in_latch` = 1.
- R10: While `rst` = 1 at a rising `clk` edge, the state becomes 0.
- R11: `feedback` carries the selected state before polarity inversion, so its value does not depend on `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock |
| rst | input | 1 | Synchronous active-high reset, clears the state |
| sum_term | input | 1 | Sum-of-products data term |
| latch_gate | input | 1 | Latch enable, transparent when 1 |
| ar_term | input | 1 | Asynchronous clear term |
| ap_term | input | 1 | Asynchronous set term |
| oe_terms | input | NUM_OE_TERMS | Candidate enable product terms |
| cfg_path | input | 2 | Data path select |
| cfg_t_type | input | 1 | 1 selects toggle storage in flip-flop mode |
| cfg_invert | input | 1 | 1 inverts the pad data |
| cfg_oe_mode | input | 2 | Output-enable mode |
| cfg_oe_sel | input | SEL_W | Index of the enable term used in product-term mode |
| cfg_in_latch | input | 1 | Buried build: 1 selects latch capture, 0 flip-flop capture |
| pin_in | input | 1 | Pad input value, sampled by the buried build |
| pin_dout | output | 1 | Data presented to the pad driver |
| pin_oe | output | 1 | Pad driver enable |
| feedback | output | 1 | State returned to the logic array |

## Verification
The bench holds two copies of the cell. One is built with the defaults (two enable terms, pad-driving), so both selector positions and every encoding of the mode fields are reachable. The other has BURIED = 1, which brings the pad-input capture through both the flip-flop and the latch within reach. On both copies the bench drives clear-and-set collisions and latch hold across clock edges, and compares each output with a model of the state kept in the bench.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        PATH_REG      = 2'b00,
        PATH_LATCH    = 2'b01,
        PATH_COMB     = 2'b10,
        PATH_COMB_ALT = 2'b11
    } path_e;

    typedef enum logic [1:0] {
        OE_ON      = 2'b00,
        OE_OFF     = 2'b01,
        OE_TERM    = 2'b10,
        OE_OFF_ALT = 2'b11
    } oe_mode_e;

    typedef struct packed {
        path_e    path;
        logic     t_type;
        logic     invert;
        oe_mode_e oe_mode;
    } mc_cfg_t;

    // Picks the state that the chosen data path presents.
    function automatic logic pick_state(path_e p, logic q_ff, logic q_lat, logic comb);
        case (p)
            PATH_REG:   return q_ff;
            PATH_LATCH: return q_lat;
            default:    return comb;
        endcase
    endfunction

    // Resolves the pad enable from its mode and the chosen enable term.
    function automatic logic resolve_oe(oe_mode_e m, logic term);
        case (m)
            OE_ON:   return 1'b1;
            OE_TERM: return term;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mc_flop.sv
module mc_flop (
    input  logic clk,
    input  logic rst,
    input  logic ar,
    input  logic ap,
    input  logic t_mode,
    input  logic d_in,
    output logic q
);
    logic d_next;

    assign d_next = t_mode ? (q ^ d_in) : d_in;

    always_ff @(posedge clk or posedge ar or posedge ap) begin
        if (ar)       q <= 1'b0;
        else if (ap)  q <= 1'b1;
        else if (rst) q <= 1'b0;
        else          q <= d_next;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        ($past(ar) && ar) |-> !q) else $error("clear term did not hold state low"); // R6

    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!ar && !ap && !rst && t_mode) && !ar && !ap) |-> (q == ($past(q) ^ $past(d_in))))
        else $error("toggle storage update wrong"); // R4

endmodule

// File: rtl/mc_latch.sv
module mc_latch (
    input  logic clk,
    input  logic rst,
    input  logic ar,
    input  logic ap,
    input  logic gate,
    input  logic d_in,
    output logic q
);
    always_latch begin
        if (ar || rst)  q = 1'b0;
        else if (ap)    q = 1'b1;
        else if (gate)  q = d_in;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!gate && $past(!gate) && !ar && !ap && $past(!ar && !ap && !rst)) |-> $stable(q))
        else $error("latch moved while closed"); // R5

endmodule

// File: rtl/mc_oe_ctl.sv
module mc_oe_ctl
    import pld_mc_pkg::*;
#(
    parameter int NUM_OE_TERMS = 2,
    localparam int SEL_W = (NUM_OE_TERMS > 1) ? $clog2(NUM_OE_TERMS) : 1
) (
    input  logic [NUM_OE_TERMS-1:0] terms,
    input  logic [SEL_W-1:0]        sel,
    input  oe_mode_e                mode,
    output logic                    oe
);
    logic chosen;

    always_comb begin
        chosen = 1'b0;
        for (int i = 0; i < NUM_OE_TERMS; i++) begin
            if (sel == SEL_W'(i)) chosen = terms[i];
        end
    end

    assign oe = resolve_oe(mode, chosen);

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_OE_TERMS = 2,
    parameter bit BURIED = 1'b0,
    localparam int SEL_W = (NUM_OE_TERMS > 1) ? $clog2(NUM_OE_TERMS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sum_term,
    input  logic                    latch_gate,
    input  logic                    ar_term,
    input  logic                    ap_term,
    input  logic [NUM_OE_TERMS-1:0] oe_terms,
    input  logic [1:0]              cfg_path,
    input  logic                    cfg_t_type,
    input  logic                    cfg_invert,
    input  logic [1:0]              cfg_oe_mode,
    input  logic [SEL_W-1:0]        cfg_oe_sel,
    input  logic                    cfg_in_latch,
    input  logic                    pin_in,
    output logic                    pin_dout,
    output logic                    pin_oe,
    output logic                    feedback
);
    mc_cfg_t cfg;

    assign cfg.path    = path_e'(cfg_path);
    assign cfg.t_type  = cfg_t_type;
    assign cfg.invert  = cfg_invert;
    assign cfg.oe_mode = oe_mode_e'(cfg_oe_mode);

    generate
        if (BURIED) begin : g_buried
            logic q_ff, q_lat;
            logic unused_cfg;
            assign unused_cfg = ^{sum_term, oe_terms, cfg, cfg_oe_sel};

            mc_flop u_in_ff (
                .clk(clk), .rst(rst), .ar(ar_term), .ap(ap_term),
                .t_mode(1'b0), .d_in(pin_in), .q(q_ff)
            );
            mc_latch u_in_lat (
                .clk(clk), .rst(rst), .ar(ar_term), .ap(ap_term),
                .gate(latch_gate), .d_in(pin_in), .q(q_lat)
            );

            assign feedback = cfg_in_latch ? q_lat : q_ff;
            assign pin_dout = 1'b0;
            assign pin_oe   = 1'b0;

            AST_BURIED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                (!cfg_in_latch && $past(!cfg_in_latch && !ar_term && !ap_term && !rst)
                 && !ar_term && !ap_term) |-> (feedback == $past(pin_in)))
                else $error("buried flop missed pad input"); // R9
        end else begin : g_output
            logic q_ff, q_lat, state;
            logic unused_in;
            assign unused_in = ^{cfg_in_latch, pin_in};

            mc_flop u_ff (
                .clk(clk), .rst(rst), .ar(ar_term), .ap(ap_term),
                .t_mode(cfg.t_type), .d_in(sum_term), .q(q_ff)
            );
            mc_latch u_lat (
                .clk(clk), .rst(rst), .ar(ar_term), .ap(ap_term),
                .gate(latch_gate), .d_in(sum_term), .q(q_lat)
            );
            mc_oe_ctl #(.NUM_OE_TERMS(NUM_OE_TERMS)) u_oe (
                .terms(oe_terms), .sel(cfg_oe_sel), .mode(cfg.oe_mode), .oe(pin_oe)
            );

            assign state    = pick_state(cfg.path, q_ff, q_lat, sum_term);
            assign feedback = state;
            assign pin_dout = state ^ cfg.invert;

            AST_FB_POLARITY: assert property (@(posedge clk) disable iff (rst)
                pin_dout == (feedback ^ cfg_invert))
                else $error("pad data and feedback disagree"); // R11

            AST_OE_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
                (cfg_oe_mode[0] == 1'b1) |-> !pin_oe)
                else $error("driver enabled in an off mode"); // R7

            AST_D_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                (cfg_path == 2'b00 && $past(cfg_path == 2'b00 && !cfg_t_type
                 && !ar_term && !ap_term && !rst) && !ar_term && !ap_term)
                |-> (feedback == $past(sum_term)))
                else $error("D flop missed sum term"); // R3
        end
    endgenerate

endmodule

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sum_term = 0, latch_gate = 0, ar_term = 0, ap_term = 0;
    logic [1:0] oe_terms = 2'b00;
    logic [1:0] cfg_path = 2'b00, cfg_oe_mode = 2'b00;
    logic cfg_t_type = 0, cfg_invert = 0, cfg_in_latch = 0, pin_in = 0;
    logic [0:0] cfg_oe_sel = 1'b0;
    logic pin_dout, pin_oe, feedback;
    logic b_dout, b_oe, b_fb;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    pld_macrocell dut (
        .clk(clk), .rst(rst), .sum_term(sum_term), .latch_gate(latch_gate),
        .ar_term(ar_term), .ap_term(ap_term), .oe_terms(oe_terms),
        .cfg_path(cfg_path), .cfg_t_type(cfg_t_type), .cfg_invert(cfg_invert),
        .cfg_oe_mode(cfg_oe_mode), .cfg_oe_sel(cfg_oe_sel), .cfg_in_latch(cfg_in_latch),
        .pin_in(pin_in), .pin_dout(pin_dout), .pin_oe(pin_oe), .feedback(feedback)
    );

    pld_macrocell #(.BURIED(1'b1)) dut_buried (
        .clk(clk), .rst(rst), .sum_term(sum_term), .latch_gate(latch_gate),
        .ar_term(ar_term), .ap_term(ap_term), .oe_terms(oe_terms),
        .cfg_path(cfg_path), .cfg_t_type(cfg_t_type), .cfg_invert(cfg_invert),
        .cfg_oe_mode(cfg_oe_mode), .cfg_oe_sel(cfg_oe_sel), .cfg_in_latch(cfg_in_latch),
        .pin_in(pin_in), .pin_dout(b_dout), .pin_oe(b_oe), .feedback(b_fb)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic t_reset;
        rst = 1'b1; cfg_path = 2'b00; cfg_invert = 0; cfg_oe_mode = 2'b00;
        tick; tick;
        chk("R10 feedback after reset", feedback, 1'b0);
        chk("R10 pad data after reset", pin_dout, 1'b0);
        chk("R10 buried state after reset", b_fb, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_dreg(input logic inv);
        logic pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        cfg_path = 2'b00; cfg_t_type = 0; cfg_invert = inv;
        foreach (pat[i]) begin
            sum_term = pat[i];
            #1;
            if (i > 0) chk("R3 state holds between edges", feedback, pat[i-1]);
            tick;
            chk("R3 D capture", feedback, pat[i]);
            chk("R2 pad polarity", pin_dout, pat[i] ^ inv);
            chk("R11 feedback ignores polarity", feedback, pat[i]);
        end
    endtask

    task automatic t_treg;
        logic pat [7] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        logic mq;
        t_reset;
        mq = 1'b0;
        cfg_path = 2'b00; cfg_t_type = 1; cfg_invert = 0;
        foreach (pat[i]) begin
            sum_term = pat[i];
            tick;
            mq = mq ^ pat[i];
            chk("R4 toggle storage", feedback, mq);
        end
        cfg_t_type = 0;
    endtask

    task automatic t_latch;
        cfg_path = 2'b01; cfg_invert = 0;
        latch_gate = 1; sum_term = 1; #1;
        chk("R5 latch open follows 1", feedback, 1'b1);
        sum_term = 0; #1;
        chk("R5 latch open follows 0", feedback, 1'b0);
        sum_term = 1; #1;
        tick;
        chk("R5 latch open across edge", feedback, 1'b1);
        latch_gate = 0; #1;
        sum_term = 0; #1;
        chk("R5 latch closed holds", feedback, 1'b1);
        tick; tick;
        chk("R5 latch holds across clocks", feedback, 1'b1);
        cfg_invert = 1; #1;
        chk("R2 latch inverted pad", pin_dout, 1'b0);
        chk("R1 latch path selected", feedback, 1'b1);
        latch_gate = 1; #1;
        chk("R5 latch reopens", feedback, 1'b0);
        tick;
        latch_gate = 0; cfg_invert = 0;
    endtask

    task automatic t_comb;
        cfg_path = 2'b10;
        for (int k = 0; k < 4; k++) begin
            cfg_invert = k[1]; sum_term = k[0]; #1;
            chk("R1 comb path pad", pin_dout, k[0] ^ k[1]);
            chk("R11 comb feedback", feedback, k[0]);
        end
        cfg_path = 2'b11; cfg_invert = 0; sum_term = 1; #1;
        chk("R1 comb alternate code", pin_dout, 1'b1);
    endtask

    task automatic t_async;
        cfg_path = 2'b00; cfg_t_type = 0; cfg_invert = 0; sum_term = 0;
        tick;
        ap_term = 1; #1;
        chk("R6 set acts without clock", feedback, 1'b0 | 1'b1);
        tick;
        chk("R6 set held over edge", feedback, 1'b1);
        ar_term = 1; #1;
        chk("R6 clear wins over set", feedback, 1'b0);
        tick;
        chk("R6 clear wins at edge", feedback, 1'b0);
        chk("R6 buried clear wins", b_fb, 1'b0);
        ap_term = 0; tick;
        ar_term = 0; tick;
        cfg_path = 2'b01; latch_gate = 0; ap_term = 1; #1;
        chk("R6 set forces latch", feedback, 1'b1);
        tick;
        ap_term = 0; ar_term = 1; #1;
        chk("R6 clear forces latch", feedback, 1'b0);
        tick;
        ar_term = 0; tick;
    endtask

    task automatic t_oe;
        cfg_oe_mode = 2'b00; oe_terms = 2'b00; #1;
        chk("R7 mode 00 always on", pin_oe, 1'b1);
        cfg_oe_mode = 2'b01; oe_terms = 2'b11; #1;
        chk("R7 mode 01 always off", pin_oe, 1'b0);
        cfg_oe_mode = 2'b11; #1;
        chk("R7 mode 11 off", pin_oe, 1'b0);
        cfg_oe_mode = 2'b10;
        for (int k = 0; k < 8; k++) begin
            cfg_oe_sel = k[2]; oe_terms = k[1:0]; #1;
            chk("R8 selected enable term", pin_oe, k[1:0] >> k[2]);
        end
        cfg_oe_mode = 2'b00; oe_terms = 0; cfg_oe_sel = 0;
    endtask

    task automatic t_buried;
        cfg_in_latch = 0;
        chk("R9 buried driver off", b_oe, 1'b0);
        pin_in = 1; tick;
        chk("R9 buried flop captures 1", b_fb, 1'b1);
        pin_in = 0; #1;
        chk("R9 buried flop waits for edge", b_fb, 1'b1);
        tick;
        chk("R9 buried flop captures 0", b_fb, 1'b0);
        chk("R9 buried pad data low", b_dout, 1'b0);
        cfg_in_latch = 1; latch_gate = 1; pin_in = 1; #1;
        chk("R9 buried latch open", b_fb, 1'b1);
        tick;
        latch_gate = 0; #1; pin_in = 0; #1;
        chk("R9 buried latch holds", b_fb, 1'b1);
        tick;
        chk("R9 buried latch holds over edge", b_fb, 1'b1);
        chk("R9 buried driver still off", b_oe, 1'b0);
        cfg_in_latch = 0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #5;
        t_reset;
        t_dreg(1'b0);
        t_dreg(1'b1);
        t_treg;
        t_latch;
        t_comb;
        t_async;
        t_oe;
        t_reset;
        t_buried;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule